// File: doc/BRIEF.md
# Read Strobe Delay Window Trainer

This block tunes the read-strobe delay of each byte lane on a two-lane (16-bit) DDR read path. For every lane it sweeps a 5-bit delay tap upward from zero. At each tap it reads back a fixed 8-byte training pattern that earlier firmware or logic has already placed in memory. It records the first tap at which the whole pattern reads cleanly, then keeps stepping until the pattern breaks. The lane is finally parked midway between those two edges. Before every single-byte read it pulses the PHY FIFO reset and clears the sticky read-status flags. A read that comes back with the "masked" or "dummy" flag raised counts as a failed byte.

A separate coarse mode sweeps both lanes together, with lane 0 in the outer loop and lane 1 in the inner loop. It stops at the first delay pair where the two probe reads return without error flags, so that a usable starting point exists before fine training. Each lane's result is shown as a 2-bit status, and a done level marks the end of a training pass or a coarse search.

Top module: `rdt_trainer_top`

## Requirements
- R1: Each lane delay is 5 bits wide and never wraps. When training has to step a lane beyond 31, that lane ends with status error (code 3) and its delay stays at 31.
- R2: Fine training of a lane starts its delay at 0. The first read issued for that lane uses tap 0.
- R3: The reference bytes, indexed 0 to 7, are 0xFE, 0x11, 0x33, 0x55, 0x77, 0x99, 0xBB and 0xDD. Byte i of lane L is read from address L + 4*i, and the bytes are read in ascending order.
- R4: Every probe read follows the same sequence. fifo_rst is high for exactly PAUSE_CYC cycles, then low for PAUSE_CYC cycles. st_clr then pulses for one cycle, and rd_req is asserted in the next cycle. No two of these three strobes are ever high at once.
- R5: A read whose rd_ack arrives with st_masked or st_dummy set counts as a mismatch, even when rd_data is correct.
- R6: In the search for the window start, any failed byte raises the delay by one and restarts the check at byte 0. When all 8 bytes pass, the current delay becomes the window start.
- R7: In the search for the window end, a full 8-byte pass raises the delay by one and repeats the check. The first failed byte stops the search, and the current delay becomes the window end.
- R8: A successful lane ends at start + ((end - start) >> 1). One extra FIFO reset pulse, with no read, comes before that final delay is written. A lane that fails gets no such pulse.
- R9: Lane 0 is trained before lane 1. lane_stat uses these codes: 0 idle, 1 ok, 2 in progress, 3 error. lane_err is high exactly when a lane's code is 3. done rises after the last lane finishes and stays high until the next start.
- R10: The coarse search steps lane 0 through 0..31 in the outer loop and lane 1 through 0..31 in the inner loop. At each pair it reads addresses 0 and 1. At the first pair where both reads carry no flags, it stops with both lanes ok and holds that pair. If all 1024 pairs fail, it raises coarse_fail and sets both lanes to error with delays at 31.
- R11: The coarse search judges each read by the status flags only. The returned data value has no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_go | input | 1 | Pulse that starts fine training of both lanes (taken only when idle) |
| coarse_go | input | 1 | Pulse that starts the coarse joint search (taken only when idle) |
| rd_req | output | 1 | One-cycle single-byte read request |
| rd_addr | output | ADDR_W | Byte address of the read |
| rd_ack | input | 1 | Read return strobe |
| rd_data | input | 8 | Returned byte, valid with rd_ack |
| st_masked | input | 1 | Sticky "masked" read error flag |
| st_dummy | input | 1 | Sticky "dummy" read error flag |
| st_clr | output | 1 | One-cycle clear of the sticky status flags |
| fifo_rst | output | 1 | PHY read FIFO reset |
| lane_dly | output | 2*5 | Delay taps, with lane n in bits [5n+4:5n] |
| lane_stat | output | 2*2 | Lane status codes, with lane n in bits [2n+1:2n] |
| lane_err | output | 2 | Per-lane error flag |
| done | output | 1 | Training or coarse search finished |
| coarse_fail | output | 1 | Coarse search found no usable pair |

## Verification
The memory model returns the pattern only inside a per-lane passing window. Outside the window it either corrupts the data or keeps the data correct and raises a masked or dummy flag. Comparing the two kinds of failure shows that flags alone cause a mismatch. A wide window, a single-tap window, a window at tap 0 and a window reaching tap 31 each test different parts of the edge search and the halving arithmetic, and they show whether the overflow-to-error path is taken. An empty window drives the start search into the error path. The coarse runs use garbage data that passes only at one chosen pair, and a model that never passes, to test the loop order, the data-blind judgement and exhaustion after 1024 pairs.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    parameter int LANES   = 2;
    parameter int DLY_W   = 5;
    parameter int PAT_LEN = 8;
    parameter int ADDR_W  = 8;

    localparam int IDX_W  = $clog2(PAT_LEN);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef logic [DLY_W-1:0] dly_t;
    typedef logic [IDX_W-1:0] idx_t;

    localparam dly_t DLY_MAX = '1;

    typedef enum logic [1:0] {
        LS_IDLE = 2'd0,
        LS_OK   = 2'd1,
        LS_BUSY = 2'd2,
        LS_ERR  = 2'd3
    } lane_stat_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        exp;
        logic              chk_data;
        logic              fifo_only;
    } probe_cmd_t;

    // Reference byte: a lead-in value then an arithmetic run of 0x22 steps.
    function automatic logic [7:0] pattern_byte(input idx_t idx);
        logic [7:0] k;
        if (idx == '0) return 8'hFE;
        k = 8'(idx) - 8'd1;
        return 8'(8'h11 + k * 8'h22);
    endfunction

    function automatic dly_t centre(input dly_t lo, input dly_t hi);
        dly_t span;
        span = hi - lo;
        return lo + (span >> 1);
    endfunction

endpackage

// File: rtl/rdt_probe.sv
module rdt_probe
    import rdt_pkg::*;
#(
    parameter int PAUSE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  probe_cmd_t        cmd,
    output logic              fin,
    output logic              good,
    output logic              fifo_rst,
    output logic              st_clr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [7:0]        rd_data,
    input  logic              st_masked,
    input  logic              st_dummy
);
    localparam int CNT_W = $clog2(PAUSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAUSE_CYC - 1);

    typedef enum logic [2:0] {
        P_IDLE, P_RHI, P_RLO, P_CLR, P_REQ, P_WAIT
    } pst_e;

    pst_e             st;
    logic [CNT_W-1:0] cnt;
    probe_cmd_t       cmd_q;
    logic             fin_q;
    logic             good_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= P_IDLE;
            cnt    <= '0;
            cmd_q  <= '0;
            fin_q  <= 1'b0;
            good_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (st)
                P_IDLE: begin
                    if (go) begin
                        cmd_q <= cmd;
                        cnt   <= '0;
                        st    <= P_RHI;
                    end
                end
                P_RHI: begin
                    if (cnt == CNT_LAST) begin
                        cnt <= '0;
                        st  <= P_RLO;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                P_RLO: begin
                    if (cnt == CNT_LAST) begin
                        cnt <= '0;
                        if (cmd_q.fifo_only) begin
                            fin_q  <= 1'b1;
                            good_q <= 1'b1;
                            st     <= P_IDLE;
                        end else begin
                            st <= P_CLR;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                P_CLR: st <= P_REQ;
                P_REQ: st <= P_WAIT;
                P_WAIT: begin
                    if (rd_ack) begin
                        fin_q  <= 1'b1;
                        good_q <= !(st_masked || st_dummy) &&
                                  (!cmd_q.chk_data || rd_data == cmd_q.exp);
                        st     <= P_IDLE;
                    end
                end
                default: st <= P_IDLE;
            endcase
        end
    end

    assign fin      = fin_q;
    assign good     = good_q;
    assign fifo_rst = (st == P_RHI);
    assign st_clr   = (st == P_CLR);
    assign rd_req   = (st == P_REQ);
    assign rd_addr  = cmd_q.addr;

    AST_REQ_AFTER_CLR: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> $past(st_clr)); // R4
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fifo_rst, st_clr, rd_req})); // R4
    AST_CLR_AFTER_FIFO: assert property (@(posedge clk) disable iff (rst)
        $rose(st_clr) |-> !$past(fifo_rst)); // R4

endmodule

// File: rtl/rdt_ctrl.sv
module rdt_ctrl
    import rdt_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         train_go,
    input  logic                         coarse_go,
    output logic                         pgo,
    output probe_cmd_t                   cmd,
    input  logic                         fin,
    input  logic                         good,
    output dly_t       [LANES-1:0]       dly,
    output lane_stat_e [LANES-1:0]       stat,
    output logic                         done,
    output logic                         coarse_fail
);
    typedef enum logic [3:0] {
        C_IDLE, C_LINIT, C_P1_GO, C_P1_WT, C_P2_GO, C_P2_WT,
        C_CTR_GO, C_CTR_WT, C_CO_GO, C_CO_WT
    } cst_e;

    localparam idx_t IDX_LAST = idx_t'(PAT_LEN - 1);
    localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

    cst_e                    st;
    logic [LANE_W-1:0]       lane;
    idx_t                    byte_i;
    dly_t                    win_s;
    dly_t       [LANES-1:0]  dly_q;
    lane_stat_e [LANES-1:0]  stat_q;
    logic                    done_q;
    logic                    cofail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= C_IDLE;
            lane     <= '0;
            byte_i   <= '0;
            win_s    <= '0;
            done_q   <= 1'b0;
            cofail_q <= 1'b0;
            for (int i = 0; i < LANES; i++) begin
                dly_q[i]  <= '0;
                stat_q[i] <= LS_IDLE;
            end
        end else begin
            case (st)
                C_IDLE: begin
                    if (train_go) begin
                        lane     <= '0;
                        done_q   <= 1'b0;
                        cofail_q <= 1'b0;
                        for (int i = 0; i < LANES; i++) stat_q[i] <= LS_IDLE;
                        st <= C_LINIT;
                    end else if (coarse_go) begin
                        byte_i   <= '0;
                        done_q   <= 1'b0;
                        cofail_q <= 1'b0;
                        for (int i = 0; i < LANES; i++) begin
                            dly_q[i]  <= '0;
                            stat_q[i] <= LS_BUSY;
                        end
                        st <= C_CO_GO;
                    end
                end
                C_LINIT: begin
                    dly_q[lane]  <= '0;
                    stat_q[lane] <= LS_BUSY;
                    byte_i       <= '0;
                    st           <= C_P1_GO;
                end
                C_P1_GO: st <= C_P1_WT;
                C_P1_WT: begin
                    if (fin) begin
                        if (good) begin
                            byte_i <= byte_i + 1'b1;
                            st     <= C_P1_GO;
                            if (byte_i == IDX_LAST) begin
                                win_s <= dly_q[lane];
                                st    <= C_P2_GO;
                            end
                        end else begin
                            byte_i <= '0;
                            if (dly_q[lane] == DLY_MAX) begin
                                stat_q[lane] <= LS_ERR;
                                if (lane == LANE_LAST) begin
                                    done_q <= 1'b1;
                                    st     <= C_IDLE;
                                end else begin
                                    lane <= lane + 1'b1;
                                    st   <= C_LINIT;
                                end
                            end else begin
                                dly_q[lane] <= dly_q[lane] + 1'b1;
                                st          <= C_P1_GO;
                            end
                        end
                    end
                end
                C_P2_GO: st <= C_P2_WT;
                C_P2_WT: begin
                    if (fin) begin
                        if (!good) begin
                            st <= C_CTR_GO;
                        end else if (byte_i != IDX_LAST) begin
                            byte_i <= byte_i + 1'b1;
                            st     <= C_P2_GO;
                        end else begin
                            byte_i <= '0;
                            if (dly_q[lane] == DLY_MAX) begin
                                stat_q[lane] <= LS_ERR;
                                if (lane == LANE_LAST) begin
                                    done_q <= 1'b1;
                                    st     <= C_IDLE;
                                end else begin
                                    lane <= lane + 1'b1;
                                    st   <= C_LINIT;
                                end
                            end else begin
                                dly_q[lane] <= dly_q[lane] + 1'b1;
                                st          <= C_P2_GO;
                            end
                        end
                    end
                end
                C_CTR_GO: st <= C_CTR_WT;
                C_CTR_WT: begin
                    if (fin) begin
                        dly_q[lane]  <= centre(win_s, dly_q[lane]);
                        stat_q[lane] <= LS_OK;
                        if (lane == LANE_LAST) begin
                            done_q <= 1'b1;
                            st     <= C_IDLE;
                        end else begin
                            lane <= lane + 1'b1;
                            st   <= C_LINIT;
                        end
                    end
                end
                C_CO_GO: st <= C_CO_WT;
                C_CO_WT: begin
                    if (fin) begin
                        if (good && byte_i == '0) begin
                            byte_i <= idx_t'(1);
                            st     <= C_CO_GO;
                        end else if (good) begin
                            for (int i = 0; i < LANES; i++) stat_q[i] <= LS_OK;
                            done_q <= 1'b1;
                            st     <= C_IDLE;
                        end else begin
                            byte_i <= '0;
                            st     <= C_CO_GO;
                            if (dly_q[1] != DLY_MAX) begin
                                dly_q[1] <= dly_q[1] + 1'b1;
                            end else if (dly_q[0] != DLY_MAX) begin
                                dly_q[0] <= dly_q[0] + 1'b1;
                                dly_q[1] <= '0;
                            end else begin
                                for (int i = 0; i < LANES; i++) stat_q[i] <= LS_ERR;
                                cofail_q <= 1'b1;
                                done_q   <= 1'b1;
                                st       <= C_IDLE;
                            end
                        end
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd           = '0;
        cmd.exp       = pattern_byte(byte_i);
        cmd.fifo_only = (st == C_CTR_GO);
        if (st == C_CO_GO) begin
            cmd.addr     = ADDR_W'(byte_i);
            cmd.chk_data = 1'b0;
        end else begin
            cmd.addr     = ADDR_W'(lane) + (ADDR_W'(byte_i) << 2);
            cmd.chk_data = 1'b1;
        end
    end

    assign pgo         = (st == C_P1_GO) || (st == C_P2_GO) ||
                         (st == C_CTR_GO) || (st == C_CO_GO);
    assign dly         = dly_q;
    assign stat        = stat_q;
    assign done        = done_q;
    assign coarse_fail = cofail_q;

    AST_WIN_ORDER: assert property (@(posedge clk) disable iff (rst)
        (st == C_CTR_GO) |-> (dly_q[lane] > win_s)); // R7

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        AST_ERR_AT_TOP: assert property (@(posedge clk) disable iff (rst)
            $rose(stat_q[g] == LS_ERR) |-> (dly_q[g] == DLY_MAX)); // R1
        AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
            (!$stable(dly_q[g]) && $past(st) != C_CTR_WT) |->
            (({1'b0, dly_q[g]} == {1'b0, $past(dly_q[g])} + 1'b1) ||
             (dly_q[g] == '0))); // R1
        AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
            done_q |-> (stat_q[g] != LS_BUSY)); // R9
    end

endmodule

// File: rtl/rdt_trainer_top.sv
module rdt_trainer_top
    import rdt_pkg::*;
#(
    parameter int PAUSE_CYC = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   train_go,
    input  logic                   coarse_go,
    output logic                   rd_req,
    output logic [ADDR_W-1:0]      rd_addr,
    input  logic                   rd_ack,
    input  logic [7:0]             rd_data,
    input  logic                   st_masked,
    input  logic                   st_dummy,
    output logic                   st_clr,
    output logic                   fifo_rst,
    output logic [LANES*DLY_W-1:0] lane_dly,
    output logic [LANES*2-1:0]     lane_stat,
    output logic [LANES-1:0]       lane_err,
    output logic                   done,
    output logic                   coarse_fail
);
    logic                    pgo;
    probe_cmd_t              cmd;
    logic                    fin;
    logic                    good;
    dly_t       [LANES-1:0]  dly;
    lane_stat_e [LANES-1:0]  stat;

    rdt_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .train_go    (train_go),
        .coarse_go   (coarse_go),
        .pgo         (pgo),
        .cmd         (cmd),
        .fin         (fin),
        .good        (good),
        .dly         (dly),
        .stat        (stat),
        .done        (done),
        .coarse_fail (coarse_fail)
    );

    rdt_probe #(.PAUSE_CYC(PAUSE_CYC)) u_probe (
        .clk       (clk),
        .rst       (rst),
        .go        (pgo),
        .cmd       (cmd),
        .fin       (fin),
        .good      (good),
        .fifo_rst  (fifo_rst),
        .st_clr    (st_clr),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .st_masked (st_masked),
        .st_dummy  (st_dummy)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_pack
        assign lane_dly[g*DLY_W +: DLY_W] = dly[g];
        assign lane_stat[g*2 +: 2]        = stat[g];
        assign lane_err[g]                = (stat[g] == LS_ERR);
    end

endmodule

// File: tb/rdt_trainer_top_tb_top.sv
`timescale 1ns/1ps
module rdt_trainer_top_tb_top;
    localparam int PAUSE = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       train_go = 1'b0;
    logic       coarse_go = 1'b0;
    logic       rd_req;
    logic [7:0] rd_addr;
    logic       rd_ack = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       st_masked = 1'b0;
    logic       st_dummy = 1'b0;
    logic       st_clr;
    logic       fifo_rst;
    logic [9:0] lane_dly;
    logic [3:0] lane_stat;
    logic [1:0] lane_err;
    logic       done;
    logic       coarse_fail;

    always #2 clk = ~clk;

    rdt_trainer_top #(.PAUSE_CYC(PAUSE)) dut_i (
        .clk(clk), .rst(rst), .train_go(train_go), .coarse_go(coarse_go),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .st_masked(st_masked), .st_dummy(st_dummy), .st_clr(st_clr),
        .fifo_rst(fifo_rst), .lane_dly(lane_dly), .lane_stat(lane_stat),
        .lane_err(lane_err), .done(done), .coarse_fail(coarse_fail)
    );

    int n_chk = 0;
    int n_fail = 0;

    // memory model configuration
    int lo [2];
    int hi [2];
    int bad_kind [2];   // 0 corrupt data, 1 masked flag, 2 dummy flag
    bit coarse_mode = 0;
    bit co_never = 0;
    int co_a = 0;
    int co_b = 0;

    function automatic logic [7:0] ref_byte(input int i);
        logic [7:0] t [8] = '{8'hFE, 8'h11, 8'h33, 8'h55, 8'h77, 8'h99, 8'hBB, 8'hDD};
        return t[i];
    endfunction

    function automatic bit model_pass(input logic [7:0] a);
        int ln;
        int d;
        ln = int'(a[1:0]);
        if (coarse_mode)
            return !co_never && lane_dly[4:0] == 5'(co_a) && lane_dly[9:5] == 5'(co_b);
        if (ln > 1) return 0;
        d = int'(lane_dly[ln*5 +: 5]);
        return d >= lo[ln] && d <= hi[ln];
    endfunction

    logic       pend = 1'b0;
    logic       p_good = 1'b0;
    logic [7:0] p_addr = 8'h00;

    always @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0; rd_ack <= 1'b0; st_masked <= 1'b0; st_dummy <= 1'b0;
        end else begin
            rd_ack <= 1'b0;
            if (st_clr) begin
                st_masked <= 1'b0; st_dummy <= 1'b0;
            end
            if (rd_req) begin
                pend   <= 1'b1;
                p_good <= model_pass(rd_addr);
                p_addr <= rd_addr;
            end else if (pend) begin
                pend   <= 1'b0;
                rd_ack <= 1'b1;
                if (coarse_mode) begin
                    rd_data <= 8'h5A;
                    if (!p_good) st_dummy <= 1'b1;
                end else begin
                    rd_data <= ref_byte(int'(p_addr[4:2]));
                    if (!p_good) begin
                        if (bad_kind[p_addr[0]] == 0) rd_data <= ref_byte(int'(p_addr[4:2])) ^ 8'h40;
                        else if (bad_kind[p_addr[0]] == 1) st_masked <= 1'b1;
                        else st_dummy <= 1'b1;
                    end
                end
            end
        end
    end

    // protocol monitors, sampled mid-cycle
    int  mon_err = 0;
    int  run = 0;
    int  pulses = 0;
    int  reads = 0;
    bit  fifo_d = 0;
    bit  clr_d = 0;
    bit  first_seen [2];
    int  first_dly [2];

    always @(negedge clk) begin
        if (!rst) begin
            if (fifo_rst) run++;
            else if (run != 0) begin
                if (run != PAUSE) mon_err++;
                run = 0;
            end
            if (fifo_rst && !fifo_d) pulses++;
            fifo_d = fifo_rst;
            if (rd_req) begin
                reads++;
                if (!clr_d) mon_err++;
                if (!coarse_mode && rd_addr[1:0] < 2 && !first_seen[rd_addr[0]]) begin
                    first_seen[rd_addr[0]] = 1;
                    first_dly[rd_addr[0]] = int'(lane_dly[rd_addr[0]*5 +: 5]);
                end
            end
            clr_d = st_clr;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    bit wd_hit = 0;
    task automatic wait_done();
        int c = 0;
        while (!done && c < 60000) begin
            @(negedge clk);
            c++;
        end
        if (!done) begin
            wd_hit = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (done)");
        end
    endtask

    task automatic pulse(input bit coarse);
        @(negedge clk);
        if (coarse) coarse_go = 1'b1; else train_go = 1'b1;
        @(negedge clk);
        coarse_go = 1'b0; train_go = 1'b0;
    endtask

    task automatic run_train(input string nm, input int l0, input int h0, input int k0,
                             input int l1, input int h1, input int k1,
                             input int e0, input int e1, input int s0, input int s1,
                             input int extra);
        int p0;
        int r0;
        lo[0] = l0; hi[0] = h0; bad_kind[0] = k0;
        lo[1] = l1; hi[1] = h1; bad_kind[1] = k1;
        coarse_mode = 0;
        first_seen[0] = 0; first_seen[1] = 0;
        p0 = pulses; r0 = reads;
        pulse(0);
        wait_done();
        chk({nm, " R9 lane0 stat"}, int'(lane_stat[1:0]), s0);
        chk({nm, " R9 lane1 stat"}, int'(lane_stat[3:2]), s1);
        chk({nm, " R9 lane_err"}, int'(lane_err), (s0 == 3 ? 1 : 0) + (s1 == 3 ? 2 : 0));
        chk({nm, " R8 lane0 dly"}, int'(lane_dly[4:0]), e0);
        chk({nm, " R8 lane1 dly"}, int'(lane_dly[9:5]), e1);
        chk({nm, " R2 lane0 first tap"}, first_dly[0], 0);
        chk({nm, " R2 lane1 first tap"}, first_dly[1], 0);
        chk({nm, " R8 extra fifo pulses"}, (pulses - p0) - (reads - r0), extra);
        chk({nm, " R4 strobe sequence"}, mon_err, 0);
    endtask

    initial begin
        lo[0] = 0; hi[0] = 31; lo[1] = 0; hi[1] = 31;
        bad_kind[0] = 0; bad_kind[1] = 0;
        first_dly[0] = -1; first_dly[1] = -1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R9 reset stat", int'(lane_stat), 0);
        chk("R9 reset done", int'(done), 0);
        chk("R1 reset dly", int'(lane_dly), 0);
        chk("R4 reset strobes", int'({fifo_rst, st_clr, rd_req}), 0);

        // R6 R7 R3: wide windows, corrupt data; centre 5+(13-5)/2=9, 0+21/2=10
        run_train("wide", 5, 12, 0, 0, 20, 0, 9, 10, 1, 1, 2);
        // R5: flags only, single-tap windows; data stays correct outside
        run_train("flag", 3, 3, 1, 0, 0, 2, 3, 0, 1, 1, 2);
        // R1: lane0 window runs to 31 (overflow in end search), lane1 empty
        run_train("edge", 20, 31, 0, 40, 40, 2, 31, 31, 3, 3, 0);

        // R10 R11: coarse search hits (2,7) with garbage data
        if (!wd_hit) begin
            coarse_mode = 1; co_never = 0; co_a = 2; co_b = 7;
            pulse(1);
            wait_done();
            chk("R10 coarse lane0", int'(lane_dly[4:0]), 2);
            chk("R10 coarse lane1", int'(lane_dly[9:5]), 7);
            chk("R11 coarse ok stat", int'(lane_stat), 5);
            chk("R10 coarse_fail low", int'(coarse_fail), 0);
        end
        // R10: exhaustive failure
        if (!wd_hit) begin
            co_never = 1;
            pulse(1);
            wait_done();
            chk("R10 coarse_fail", int'(coarse_fail), 1);
            chk("R10 exhausted dly", int'(lane_dly), 10'h3FF);
            chk("R10 exhausted stat", int'(lane_stat), 15);
            chk("R4 coarse strobes", mon_err, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule